// File: doc/BRIEF.md
# Serial FIFO DMA Request Generator

This block produces the transmit and receive DMA request lines for a FIFO-based serial controller that moves data in demand transfer mode. It watches the fill level of the transmit FIFO and the receive FIFO, together with a receive time-out flag. It raises a request when a FIFO needs service, judged against a threshold that software selects. The thresholds depend on the FIFO depth, which is fixed when the block is built.

Two policies decide when a request ends. In the timed policy, a request follows its level condition, and a shared burst timer forces both requests low for one clock after a fixed number of consecutive serviced cycles. In the drain policy, a request stays asserted once raised: the transmit request holds until its FIFO is full, and the receive request holds until its FIFO is empty.

A swap control chooses which of the two external request/acknowledge pairs serves the transmitter and which serves the receiver. With a single external DMA channel wired to pair 0, software can point that channel at either direction.

Top module: `uart_dma_req_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, both external requests are 0. All control inputs are taken as 0 at reset by the surrounding register logic.
- R2: With `fair_mode`=0, the transmit request is 1 in the cycle after the transmit level is strictly below the transmit threshold, and 0 otherwise. The threshold is 13 (`thr_sel`=0) or 7 (`thr_sel`=1) for a 16-entry FIFO, and 29 or 23 for a 32-entry FIFO.
- R3: With `fair_mode`=0, the receive request is 1 in the cycle after the receive level is at least the receive threshold, or after `rx_timeout` is 1. The receive threshold is 4 (`thr_sel`=0) or 10 (`thr_sel`=1).
- R4: With `fair_mode`=0, after `FAIR_LIMIT` consecutive cycles in which a request is high and its acknowledge is high, both requests go to 0 for exactly one cycle. They then follow their conditions again.
- R5: The burst count restarts from zero after any cycle in which no request is being acknowledged.
- R6: With `fair_mode`=1, a raised transmit request stays 1 until the cycle after the transmit level equals the FIFO depth. It rises again only when the level is below the threshold.
- R7: With `fair_mode`=1, a raised receive request stays 1 until the cycle after the receive level is 0. It rises again on the threshold or on a time-out.
- R8: With `swap_en`=0, `ext_req0`/`ext_ack0` belong to the transmitter and `ext_req1`/`ext_ack1` belong to the receiver.
- R9: With `swap_en`=1, the pairs are exchanged, and this applies to the acknowledges as well as to the requests.
- R10: With `fair_mode`=1, no burst limit applies, however long the acknowledges are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_sel | input | 1 | Threshold table select |
| fair_mode | input | 1 | 0: timed burst limit, 1: hold until full/empty |
| swap_en | input | 1 | Exchange the TX/RX external pairs |
| tx_level | input | $clog2(FIFO_DEPTH+1) | Transmit FIFO fill level |
| rx_level | input | $clog2(FIFO_DEPTH+1) | Receive FIFO fill level |
| rx_timeout | input | 1 | Receive FIFO time-out flag |
| ext_ack0 | input | 1 | External acknowledge, pair 0 |
| ext_ack1 | input | 1 | External acknowledge, pair 1 |
| ext_req0 | output | 1 | External request, pair 0 |
| ext_req1 | output | 1 | External request, pair 1 |

## Verification
The assertions take for granted that the level inputs never exceed `FIFO_DEPTH`. They also assume that the control bits change only between cycles, since the registered requests react to the values seen at each edge. The stimulus keeps every level in 0..FIFO_DEPTH and sweeps that whole range for both threshold settings. Each test ends with a quiet period, with no condition true and both acknowledges low, so that no burst count or held request carries into the next check.

// File: rtl/udr_pkg.sv
// Package: shared constants for the DMA request generator.
// Assumes: FIFO depths of 16 or 32 entries only.
package udr_pkg;
    localparam int RX_THR_LO = 4;
    localparam int RX_THR_HI = 10;
    localparam int TX_THR16_LO = 13;
    localparam int TX_THR16_HI = 7;
    localparam int TX_THR32_LO = 29;
    localparam int TX_THR32_HI = 23;
endpackage

// File: rtl/udr_thresh.sv
// Module: udr_thresh
// Compares the FIFO levels against the selected thresholds and flags the
// full and empty conditions. Purely combinational.
// Assumes: levels never exceed FIFO_DEPTH; FIFO_DEPTH is 16 or 32.
module udr_thresh #(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             thr_sel,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_timeout,
    output logic             tx_below,
    output logic             rx_ready,
    output logic             tx_full,
    output logic             rx_empty
);
    import udr_pkg::*;

    logic [LVL_W-1:0] tx_thr_lo, tx_thr_hi, tx_thr;
    logic [LVL_W-1:0] rx_thr;

    // The FIFO depth picks the transmit threshold column.
    generate
        if (FIFO_DEPTH == 32) begin : g_deep
            assign tx_thr_lo = LVL_W'(TX_THR32_LO);
            assign tx_thr_hi = LVL_W'(TX_THR32_HI);
        end else begin : g_shallow
            assign tx_thr_lo = LVL_W'(TX_THR16_LO);
            assign tx_thr_hi = LVL_W'(TX_THR16_HI);
        end
    endgenerate

    // Apply the threshold select and form the level conditions.
    always_comb begin
        tx_thr   = thr_sel ? tx_thr_hi : tx_thr_lo;
        rx_thr   = thr_sel ? LVL_W'(RX_THR_HI) : LVL_W'(RX_THR_LO);
        tx_below = tx_level < tx_thr;
        rx_ready = (rx_level >= rx_thr) || rx_timeout;
        tx_full  = tx_level == LVL_W'(FIFO_DEPTH);
        rx_empty = rx_level == '0;
    end
endmodule

// File: rtl/udr_fair_timer.sv
// Module: udr_fair_timer
// Counts consecutive serviced cycles and pulses 'fire' on the cycle that
// completes FAIR_LIMIT of them. The count clears whenever nothing is being
// serviced, when the timer is disabled, or after it fires.
// Assumes: FAIR_LIMIT >= 1.
module udr_fair_timer #(
    parameter int FAIR_LIMIT = 2625,
    parameter int CNT_W      = $clog2(FAIR_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic busy,
    output logic fire
);
    logic [CNT_W-1:0] cnt;

    // Detect the last cycle of an allowed burst.
    always_comb fire = enable && busy && (cnt == CNT_W'(FAIR_LIMIT - 1));

    // Advance or clear the burst counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !busy || fire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/udr_req_ctrl.sv
// Module: udr_req_ctrl
// One request line. In timed mode it follows its start condition, cleared
// for one cycle by a timer fire. In drain mode it latches on the start
// condition and holds until the stop condition.
// Assumes: start/stop are stable around the clock edge.
module udr_req_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic drain_mode,
    input  logic start,
    input  logic stop,
    input  logic fire,
    output logic req
);
    // Register the request according to the active policy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else if (drain_mode) begin
            req <= req ? !stop : start;
        end else begin
            req <= start && !fire;
        end
    end
endmodule

// File: rtl/udr_swap.sv
// Module: udr_swap
// Routes the internal TX/RX request/acknowledge pairs onto external pairs
// 0 and 1, straight through or exchanged. Purely combinational.
module udr_swap (
    input  logic swap_en,
    input  logic tx_req,
    input  logic rx_req,
    input  logic ext_ack0,
    input  logic ext_ack1,
    output logic ext_req0,
    output logic ext_req1,
    output logic tx_ack,
    output logic rx_ack
);
    // Select the direction of each pair.
    always_comb begin
        ext_req0 = swap_en ? rx_req : tx_req;
        ext_req1 = swap_en ? tx_req : rx_req;
        tx_ack   = swap_en ? ext_ack1 : ext_ack0;
        rx_ack   = swap_en ? ext_ack0 : ext_ack1;
    end
endmodule

// File: rtl/uart_dma_req_gen.sv
// Module: uart_dma_req_gen (top)
// DMA request generator for a FIFO-based serial controller in demand
// transfer mode. Requests are registered: they respond one cycle after
// their inputs.
// Assumes: levels within 0..FIFO_DEPTH; FIFO_DEPTH is 16 or 32;
// FAIR_LIMIT is the burst length in clocks (2625 = 10.5 us at 250 MHz).
module uart_dma_req_gen #(
    parameter int FIFO_DEPTH = 16,
    parameter int FAIR_LIMIT = 2625,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_sel,
    input  logic             fair_mode,
    input  logic             swap_en,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_timeout,
    input  logic             ext_ack0,
    input  logic             ext_ack1,
    output logic             ext_req0,
    output logic             ext_req1
);
    logic tx_below, rx_ready, tx_full, rx_empty;
    logic tx_req, rx_req, tx_ack, rx_ack;
    logic busy, fire;

    udr_thresh #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_thresh (
        .thr_sel    (thr_sel),
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .rx_timeout (rx_timeout),
        .tx_below   (tx_below),
        .rx_ready   (rx_ready),
        .tx_full    (tx_full),
        .rx_empty   (rx_empty)
    );

    // A cycle is serviced when any raised request is acknowledged.
    always_comb busy = (tx_req && tx_ack) || (rx_req && rx_ack);

    udr_fair_timer #(.FAIR_LIMIT(FAIR_LIMIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (!fair_mode),
        .busy   (busy),
        .fire   (fire)
    );

    udr_req_ctrl u_tx_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .drain_mode (fair_mode),
        .start      (tx_below),
        .stop       (tx_full),
        .fire       (fire),
        .req        (tx_req)
    );

    udr_req_ctrl u_rx_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .drain_mode (fair_mode),
        .start      (rx_ready),
        .stop       (rx_empty),
        .fire       (fire),
        .req        (rx_req)
    );

    udr_swap u_swap (
        .swap_en  (swap_en),
        .tx_req   (tx_req),
        .rx_req   (rx_req),
        .ext_ack0 (ext_ack0),
        .ext_ack1 (ext_ack1),
        .ext_req0 (ext_req0),
        .ext_req1 (ext_req1),
        .tx_ack   (tx_ack),
        .rx_ack   (rx_ack)
    );
endmodule

// File: rtl/udr_checker.sv
// Module: udr_checker
// Property checks for uart_dma_req_gen, attached by bind.
// Assumes: levels within 0..FIFO_DEPTH.
module udr_checker #(
    parameter int FIFO_DEPTH = 16,
    parameter int FAIR_LIMIT = 2625,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             thr_sel,
    input logic             fair_mode,
    input logic             swap_en,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_timeout,
    input logic             ext_ack0,
    input logic             ext_ack1,
    input logic             ext_req0,
    input logic             ext_req1,
    input logic             tx_req,
    input logic             rx_req
);
    int tx_thr_c, rx_thr_c, burst_c;
    logic tx_ack_c, rx_ack_c;

    // Thresholds from the depth arithmetic (depth-9 / depth-3; 10 / 4).
    always_comb begin
        tx_thr_c = FIFO_DEPTH - (thr_sel ? 9 : 3);
        rx_thr_c = thr_sel ? 10 : 4;
        tx_ack_c = swap_en ? ext_ack1 : ext_ack0;
        rx_ack_c = swap_en ? ext_ack0 : ext_ack1;
    end

    // Independent count of consecutive serviced cycles in timed mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_c <= 0;
        end else if (!fair_mode && ((tx_req && tx_ack_c) || (rx_req && rx_ack_c))) begin
            burst_c <= burst_c + 1;
        end else begin
            burst_c <= 0;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ext_req0 && !ext_req1));

    p_tx_above_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fair_mode && int'(tx_level) >= tx_thr_c) |=> !tx_req);

    p_rx_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fair_mode && int'(rx_level) < rx_thr_c && !rx_timeout) |=> !rx_req);

    p_burst_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        burst_c <= FAIR_LIMIT);

    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fair_mode && tx_req && int'(tx_level) == FIFO_DEPTH) |=> !tx_req);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fair_mode && tx_req && int'(tx_level) != FIFO_DEPTH) |=> tx_req);

    p_empty_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fair_mode && rx_req && rx_level == '0) |=> !rx_req);

    p_route_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ext_req0, ext_req1}) == $countones({tx_req, rx_req}));
endmodule

bind uart_dma_req_gen udr_checker #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .FAIR_LIMIT (FAIR_LIMIT),
    .LVL_W      (LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .thr_sel    (thr_sel),
    .fair_mode  (fair_mode),
    .swap_en    (swap_en),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .rx_timeout (rx_timeout),
    .ext_ack0   (ext_ack0),
    .ext_ack1   (ext_ack1),
    .ext_req0   (ext_req0),
    .ext_req1   (ext_req1),
    .tx_req     (tx_req),
    .rx_req     (rx_req)
);

// File: tb/uart_dma_req_gen_tb.sv
// Bench for uart_dma_req_gen: level sweeps, burst limit, drain policy, swap.
module uart_dma_req_gen_tb;
    localparam int DEPTH = 16;
    localparam int LIM   = 6;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic thr_sel = 1'b0, fair_mode = 1'b0, swap_en = 1'b0;
    logic [LW-1:0] tx_level = LW'(DEPTH), rx_level = '0;
    logic rx_timeout = 1'b0, ext_ack0 = 1'b0, ext_ack1 = 1'b0;
    logic ext_req0, ext_req1;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_dma_req_gen #(.FIFO_DEPTH(DEPTH), .FAIR_LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel), .fair_mode(fair_mode),
        .swap_en(swap_en), .tx_level(tx_level), .rx_level(rx_level),
        .rx_timeout(rx_timeout), .ext_ack0(ext_ack0), .ext_ack1(ext_ack1),
        .ext_req0(ext_req0), .ext_req1(ext_req1)
    );

    function automatic int tx_thr(input logic sel);
        return (DEPTH == 16) ? (sel ? 7 : 13) : (sel ? 23 : 29);
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic quiet();
        tx_level = LW'(DEPTH); rx_level = '0; rx_timeout = 0;
        ext_ack0 = 0; ext_ack1 = 0;
        cyc(); cyc();
    endtask

    initial begin
        // R1: reset holds requests low even with conditions true
        tx_level = '0; rx_level = LW'(DEPTH);
        cyc(); cyc();
        chk("R1 reset req0", ext_req0, 1'b0);
        chk("R1 reset req1", ext_req1, 1'b0);
        rst_n = 1'b1;
        quiet();
        chk("R1 idle req0", ext_req0, 1'b0);

        // R2/R3: sweep levels, both threshold tables, timed mode, no ack
        for (int s = 0; s < 2; s++) begin
            thr_sel = s[0];
            for (int l = 0; l <= DEPTH; l++) begin
                for (int t = 0; t < 2; t++) begin
                    tx_level = LW'(l); rx_level = LW'(l); rx_timeout = t[0];
                    cyc();
                    chk("R2 tx level", ext_req0, l < tx_thr(s[0]));
                    chk("R3 rx level", ext_req1,
                        (l >= (s[0] ? 10 : 4)) || (t == 1));
                end
            end
        end
        thr_sel = 0;
        quiet();

        // R4: continuous burst, both requests drop for one cycle
        tx_level = '0; rx_level = LW'(DEPTH); ext_ack0 = 1;
        for (int i = 1; i <= LIM; i++) begin
            cyc();
            chk("R4 burst high", ext_req0, 1'b1);
        end
        cyc();
        chk("R4 forced low tx", ext_req0, 1'b0);
        chk("R4 forced low rx", ext_req1, 1'b0);
        cyc();
        chk("R4 reassert tx", ext_req0, 1'b1);
        chk("R4 reassert rx", ext_req1, 1'b1);
        quiet();

        // R5: one unacknowledged cycle restarts the count
        tx_level = '0; ext_ack0 = 1;
        for (int i = 1; i <= LIM + 3; i++) begin
            cyc();
            chk("R5 burst high", ext_req0, 1'b1);
            if (i == 3) ext_ack0 = 0;
            if (i == 4) ext_ack0 = 1;
        end
        cyc();
        chk("R5 forced low", ext_req0, 1'b0);
        quiet();

        // R6: drain mode transmit hysteresis
        fair_mode = 1;
        tx_level = LW'(10); cyc(); chk("R6 tx rise", ext_req0, 1'b1);
        tx_level = LW'(14); cyc(); chk("R6 tx hold 14", ext_req0, 1'b1);
        tx_level = LW'(DEPTH - 1); cyc(); chk("R6 tx hold 15", ext_req0, 1'b1);
        tx_level = LW'(DEPTH); cyc(); chk("R6 tx drop full", ext_req0, 1'b0);
        tx_level = LW'(14); cyc(); chk("R6 tx stays low", ext_req0, 1'b0);
        tx_level = LW'(12); cyc(); chk("R6 tx rise again", ext_req0, 1'b1);

        // R10: no burst limit in drain mode
        ext_ack0 = 1;
        for (int i = 1; i <= 3 * LIM; i++) begin
            cyc();
            chk("R10 no limit", ext_req0, 1'b1);
        end
        ext_ack0 = 0;
        tx_level = LW'(DEPTH); cyc();

        // R7: drain mode receive hysteresis
        rx_level = LW'(3); cyc(); chk("R7 rx below", ext_req1, 1'b0);
        rx_level = LW'(4); cyc(); chk("R7 rx rise", ext_req1, 1'b1);
        rx_level = LW'(1); cyc(); chk("R7 rx hold", ext_req1, 1'b1);
        rx_level = '0; cyc(); chk("R7 rx drop empty", ext_req1, 1'b0);
        rx_level = LW'(2); cyc(); chk("R7 rx stays low", ext_req1, 1'b0);
        rx_timeout = 1; cyc(); chk("R7 rx timeout rise", ext_req1, 1'b1);
        fair_mode = 0;
        quiet();

        // R8: straight routing
        tx_level = '0; cyc();
        chk("R8 tx on pair0", ext_req0, 1'b1);
        chk("R8 pair1 idle", ext_req1, 1'b0);
        quiet();

        // R9: swapped routing of requests
        swap_en = 1;
        tx_level = '0; cyc();
        chk("R9 tx on pair1", ext_req1, 1'b1);
        chk("R9 pair0 idle", ext_req0, 1'b0);
        quiet();
        // R9: pair0 ack no longer services the transmitter
        tx_level = '0; ext_ack0 = 1;
        for (int i = 1; i <= 2 * LIM; i++) begin
            cyc();
            chk("R9 ack0 ignored", ext_req1, 1'b1);
        end
        quiet();
        // R9: pair1 ack drives the transmitter burst limit
        tx_level = '0; ext_ack1 = 1;
        for (int i = 1; i <= LIM; i++) cyc();
        chk("R9 ack1 burst high", ext_req1, 1'b1);
        cyc();
        chk("R9 ack1 forced low", ext_req1, 1'b0);
        quiet();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule